// File: doc/BRIEF.md
# Dual-Lane Accumulator Saturation Stage

This block sits behind a pair of 40-bit multiply-accumulate lanes. Each lane delivers a raw accumulated sum that is wider than 40 bits. The stage clamps that sum according to the arithmetic mode of the operation, registers the clamped 40-bit value, and keeps a per-lane overflow flag with a sticky companion. It also merges both lanes into one shared overflow flag, which has its own sticky copy.

One mode select applies to both lanes. Each lane has its own enable, mixed-mode bit, full-word result bit and multiplier-saturation input. Results and flags appear one clock after the inputs. A synchronous reset clears every register. An unused mode encoding on an active operation raises an illegal-operation output, and nothing else changes in that cycle.

Top module: `mac_sat_pair`

## Requirements
- R1: Mode 0 (signed fractional) clamps the sum to the 40-bit signed range, giving 0x7FFFFFFFFF above it and 0x8000000000 below it. A clamp sets the lane's saturation.
- R2: Modes 1, 2 and 3 (unsigned fractional, truncated unsigned fractional, unsigned integer) behave as follows with the mixed bit at 0. A negative sum gives 0. A sum above 0xFFFFFFFFFF gives 0xFFFFFFFFFF. Either case sets saturation.
- R3: In modes 1, 2 and 3 with the mixed bit at 1, the result is the low 40 bits of the sum and saturation stays 0. The mixed bit has no effect in the other modes.
- R4: Mode 4 (integer high) clamps the sum to the 32-bit signed range and sign-extends the result to 40 bits. The bounds are 0x007FFFFFFF and 0xFF80000000. A clamp sets saturation.
- R5: Mode 5 (32-bit wrap) examines bits 39 down to 31 of the sum. If they differ, the result becomes 0x80000000 when bit 39 is 1, or 0x7FFFFFFF when bit 39 is 0. The 32-bit result is sign-extended to 40 bits. Saturation is set on such a clamp, and also whenever the lane's multiplier-saturation input is 1. That input has no effect in other modes.
- R6: On each legal cycle, an enabled lane's flag takes that cycle's saturation value. Its sticky flag is set on saturation and never cleared except by reset.
- R7: On each legal cycle, the shared flag is the OR of the two lanes' overflow outputs. The shared sticky flag sets whenever the shared flag's new value is 1.
- R8: A disabled lane keeps its accumulator, flag and sticky flag, and contributes 0 to the shared flag.
- R9: A lane's overflow output is 0 without saturation. With saturation it is 1 when the lane's full-word bit is 1. Otherwise it is 1 only when the raw sum lies outside the 32-bit signed range.
- R10: Mode codes 6 and 7 with at least one lane enabled register the illegal output as 1. In that cycle all accumulators and flags keep their values.
- R11: Results appear one clock after the inputs. A synchronous reset clears the accumulators, all flags and the illegal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 3 | Arithmetic mode shared by both lanes |
| sum0 | input | SUM_W | Raw sum, lane 0, two's complement |
| sum1 | input | SUM_W | Raw sum, lane 1, two's complement |
| en0 | input | 1 | Lane 0 takes part in the operation |
| en1 | input | 1 | Lane 1 takes part in the operation |
| mixed0 | input | 1 | Lane 0 mixed-mode bit |
| mixed1 | input | 1 | Lane 1 mixed-mode bit |
| full0 | input | 1 | Lane 0 result is a full word |
| full1 | input | 1 | Lane 1 result is a full word |
| msat0 | input | 1 | Lane 0 multiplier saturated |
| msat1 | input | 1 | Lane 1 multiplier saturated |
| acc0 | output | ACC_W | Clamped accumulator, lane 0 |
| acc1 | output | ACC_W | Clamped accumulator, lane 1 |
| av0 | output | 1 | Lane 0 saturation flag |
| avs0 | output | 1 | Lane 0 sticky saturation flag |
| av1 | output | 1 | Lane 1 saturation flag |
| avs1 | output | 1 | Lane 1 sticky saturation flag |
| v | output | 1 | Shared overflow flag |
| vs | output | 1 | Shared sticky overflow flag |
| illegal | output | 1 | Unused mode encoding seen |

## Verification
The case of interest is two lanes that both saturate in one cycle under different result widths. One lane is a full word and always reports overflow. The other is a half word, and its overflow depends on the unclamped sum. The shared flag must be the OR of the two lanes' overflow outputs. The bench drives independent random sums near the 2^31, 2^39 and 2^40 boundaries into both lanes at once, with random enables and full-word bits. It then compares both accumulators, the lane flags and the merged flag against a model in the bench that tracks every flag, sticky flags included. Directed cycles place one lane's clamp next to an idle or non-saturating second lane, and they place an illegal mode directly after a saturation.

// File: rtl/mac_sat_pair.sv
module mac_sat_pair #(
  parameter int ACC_W = 40,
  parameter int SUM_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [SUM_W-1:0] sum0,
  input  logic [SUM_W-1:0] sum1,
  input  logic             en0,
  input  logic             en1,
  input  logic             mixed0,
  input  logic             mixed1,
  input  logic             full0,
  input  logic             full1,
  input  logic             msat0,
  input  logic             msat1,
  output logic [ACC_W-1:0] acc0,
  output logic [ACC_W-1:0] acc1,
  output logic             av0,
  output logic             avs0,
  output logic             av1,
  output logic             avs1,
  output logic             v,
  output logic             vs,
  output logic             illegal
);
  localparam int WW = 32;
  localparam logic [2:0] M_SF = 3'd0, M_UF = 3'd1, M_TUF = 3'd2,
                         M_UI = 3'd3, M_IH = 3'd4, M_W32 = 3'd5;

  function automatic logic fits(input logic [SUM_W-1:0] s, input int w);
    logic [SUM_W-1:0] top;
    top = s >> (w - 1);
    return (top == '0) || (top == {SUM_W{1'b1}} >> (w - 1));
  endfunction

  // returns {sat, value}
  function automatic logic [ACC_W:0] clamp(input logic [SUM_W-1:0] s, input logic [2:0] m,
                                          input logic mx, input logic ms);
    logic neg;
    logic [ACC_W-1:0] lo, pmax, nmin, wmax, wmin;
    logic [ACC_W-WW:0] wt;
    neg  = s[SUM_W-1];
    lo   = s[ACC_W-1:0];
    pmax = {1'b0, {(ACC_W-1){1'b1}}};
    nmin = {1'b1, {(ACC_W-1){1'b0}}};
    wmax = {{(ACC_W-WW+1){1'b0}}, {(WW-1){1'b1}}};
    wmin = {{(ACC_W-WW+1){1'b1}}, {(WW-1){1'b0}}};
    wt   = lo[ACC_W-1:WW-1];
    case (m)
      M_SF:  return fits(s, ACC_W) ? {1'b0, lo} : {1'b1, neg ? nmin : pmax};
      M_UF, M_TUF, M_UI:
        if (mx)                          return {1'b0, lo};
        else if (neg)                    return {1'b1, {ACC_W{1'b0}}};
        else if (|s[SUM_W-1:ACC_W])      return {1'b1, {ACC_W{1'b1}}};
        else                             return {1'b0, lo};
      M_IH:  return fits(s, WW) ? {1'b0, lo} : {1'b1, neg ? wmin : wmax};
      M_W32:
        if ((&wt) || ~|wt)               return {ms, lo};
        else                             return {1'b1, lo[ACC_W-1] ? wmin : wmax};
      default:                           return '0;
    endcase
  endfunction

  logic [ACC_W:0] r0, r1;
  logic           ov0, ov1, vn, ill;

  assign r0  = clamp(sum0, mode, mixed0, msat0);
  assign r1  = clamp(sum1, mode, mixed1, msat1);
  assign ov0 = en0 & r0[ACC_W] & (full0 | ~fits(sum0, WW));
  assign ov1 = en1 & r1[ACC_W] & (full1 | ~fits(sum1, WW));
  assign vn  = ov0 | ov1;
  assign ill = (mode > M_W32) & (en0 | en1);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc0 <= '0; acc1 <= '0;
      av0 <= 1'b0; avs0 <= 1'b0; av1 <= 1'b0; avs1 <= 1'b0;
      v <= 1'b0; vs <= 1'b0; illegal <= 1'b0;
    end else begin
      illegal <= ill;
      if (!ill) begin
        if (en0) begin
          acc0 <= r0[ACC_W-1:0];
          av0  <= r0[ACC_W];
          if (r0[ACC_W]) avs0 <= 1'b1;
        end
        if (en1) begin
          acc1 <= r1[ACC_W-1:0];
          av1  <= r1[ACC_W];
          if (r1[ACC_W]) avs1 <= 1'b1;
        end
        v <= vn;
        if (vn) vs <= 1'b1;
      end
    end
  end
endmodule

module mac_sat_pair_chk #(
  parameter int ACC_W = 40
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       mode,
  input logic             en0,
  input logic [ACC_W-1:0] acc0,
  input logic [ACC_W-1:0] acc1,
  input logic             av0,
  input logic             avs0,
  input logic             av1,
  input logic             avs1,
  input logic             v,
  input logic             vs,
  input logic             illegal
);
  logic seen = 1'b0;
  always_ff @(posedge clk) if (rst) seen <= 1'b1;

  a_r6_sticky0_holds: assert property (@(posedge clk) disable iff (rst) avs0 |=> avs0);
  a_r6_sticky1_holds: assert property (@(posedge clk) disable iff (rst) avs1 |=> avs1);
  a_r6_flag_in_sticky: assert property (@(posedge clk) disable iff (rst)
    (av0 |-> avs0) and (av1 |-> avs1));
  a_r7_shared_sticky: assert property (@(posedge clk) disable iff (rst) vs |=> vs);
  a_r7_v_in_vs: assert property (@(posedge clk) disable iff (rst) v |-> vs);
  a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && illegal) |->
      ($stable(acc0) && $stable(acc1) && $stable(avs0) && $stable(avs1) && $stable(vs)));
  a_r8_idle_lane0: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && !$past(en0)) |-> ($stable(acc0) && $stable(av0) && $stable(avs0)));
  a_r5_wrap_range: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst) && $past(en0) && $past(mode) == 3'd5 && !illegal) |->
      ((&acc0[ACC_W-1:31]) || !(|acc0[ACC_W-1:31])));
endmodule

bind mac_sat_pair mac_sat_pair_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .en0(en0), .acc0(acc0), .acc1(acc1),
  .av0(av0), .avs0(avs0), .av1(av1), .avs1(avs1), .v(v), .vs(vs), .illegal(illegal));

// File: tb/test_mac_sat_pair.sv
`timescale 1ns/1ps
module test_mac_sat_pair;
  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] mode = '0;
  logic [47:0] sum0 = '0, sum1 = '0;
  logic en0 = 0, en1 = 0, mixed0 = 0, mixed1 = 0, full0 = 0, full1 = 0, msat0 = 0, msat1 = 0;
  logic [39:0] acc0, acc1;
  logic av0, avs0, av1, avs1, v, vs, illegal;

  mac_sat_pair i_mac_sat_pair (.*);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [39:0] e_acc0 = '0, e_acc1 = '0;
  logic e_av0 = 0, e_avs0 = 0, e_av1 = 0, e_avs1 = 0, e_v = 0, e_vs = 0, e_ill = 0;
  string t0 = "R11", t1 = "R11";

  localparam longint P39 = 64'sd549755813887;
  localparam longint N39 = -64'sd549755813888;
  localparam longint U40 = 64'sd1099511627775;
  localparam longint P31 = 64'sd2147483647;
  localparam longint N31 = -64'sd2147483648;

  function automatic longint sx48(input logic [47:0] x);
    return longint'({{16{x[47]}}, x});
  endfunction

  function automatic logic [40:0] model(input logic [47:0] x, input logic [2:0] m,
                                        input logic mx, input logic ms);
    longint s = sx48(x), t;
    if (m == 3'd0) begin
      if (s > P39) return {1'b1, 40'h7FFFFFFFFF};
      if (s < N39) return {1'b1, 40'h8000000000};
      return {1'b0, x[39:0]};
    end
    if (m >= 3'd1 && m <= 3'd3) begin
      if (mx) return {1'b0, x[39:0]};
      if (s < 0) return {1'b1, 40'h0};
      if (s > U40) return {1'b1, 40'hFFFFFFFFFF};
      return {1'b0, x[39:0]};
    end
    if (m == 3'd4) begin
      if (s > P31) return {1'b1, 40'h007FFFFFFF};
      if (s < N31) return {1'b1, 40'hFF80000000};
      return {1'b0, x[39:0]};
    end
    t = longint'({{24{x[39]}}, x[39:0]});
    if (t > P31) return {1'b1, 40'h007FFFFFFF};
    if (t < N31) return {1'b1, 40'hFF80000000};
    return {ms, x[39:0]};
  endfunction

  function automatic string tagof(input logic [2:0] m, input logic mx, input logic en);
    if (m > 3'd5 && (en0 | en1)) return "R10";
    if (!en) return "R8";
    case (m)
      3'd0: return "R1";
      3'd4: return "R4";
      3'd5: return "R5";
      default: return mx ? "R3" : "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic compare_all();
    chk({t0, " acc0"}, acc0, e_acc0);
    chk({t1, " acc1"}, acc1, e_acc1);
    chk("R6 av0", 40'(av0), 40'(e_av0));
    chk("R6 avs0", 40'(avs0), 40'(e_avs0));
    chk("R6 av1", 40'(av1), 40'(e_av1));
    chk("R6 avs1", 40'(avs1), 40'(e_avs1));
    chk("R7 R9 v", 40'(v), 40'(e_v));
    chk("R7 vs", 40'(vs), 40'(e_vs));
    chk("R10 illegal", 40'(illegal), 40'(e_ill));
  endtask

  task automatic step();
    logic [40:0] r0, r1;
    logic o0, o1, ill;
    longint s0, s1;
    r0 = model(sum0, mode, mixed0, msat0);
    r1 = model(sum1, mode, mixed1, msat1);
    s0 = sx48(sum0); s1 = sx48(sum1);
    o0 = en0 && r0[40] && (full0 || s0 > P31 || s0 < N31);
    o1 = en1 && r1[40] && (full1 || s1 > P31 || s1 < N31);
    ill = (mode > 3'd5) && (en0 || en1);
    t0 = tagof(mode, mixed0, en0);
    t1 = tagof(mode, mixed1, en1);
    @(posedge clk);
    e_ill = ill;
    if (!ill) begin
      if (en0) begin e_acc0 = r0[39:0]; e_av0 = r0[40]; e_avs0 |= r0[40]; end
      if (en1) begin e_acc1 = r1[39:0]; e_av1 = r1[40]; e_avs1 |= r1[40]; end
      e_v = o0 | o1;
      e_vs |= e_v;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic drive(input logic [2:0] m, input logic [47:0] a, input logic [47:0] b,
                       input logic [1:0] en, input logic [1:0] mx,
                       input logic [1:0] fw, input logic [1:0] ms);
    mode = m; sum0 = a; sum1 = b;
    {en1, en0} = en; {mixed1, mixed0} = mx; {full1, full0} = fw; {msat1, msat0} = ms;
    step();
  endtask

  function automatic logic [47:0] pick();
    int k = int'($urandom % 6);
    longint d = longint'($urandom % 7) - 3;
    longint b;
    case (k)
      0: b = longint'($urandom % 65536);
      1: b = 64'sd1 <<< 31;
      2: b = 64'sd1 <<< 39;
      3: b = 64'sd1 <<< 40;
      4: b = longint'({$urandom, $urandom});
      default: b = longint'($urandom) <<< ($urandom % 17);
    endcase
    b = b + d;
    if ($urandom % 2) b = -b;
    return b[47:0];
  endfunction

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    t0 = "R11"; t1 = "R11";
    compare_all();
    rst = 1'b0;
    // R1 positive clamp lane0 full word, lane1 idle
    drive(3'd0, 48'h0080_0000_0000, 48'h0, 2'b01, 2'b00, 2'b01, 2'b00);
    // R1 negative clamp, R9 half word on both lanes, lane1 in-range
    drive(3'd0, 48'hFF7F_FFFF_FFFF, 48'h0000_0000_1234, 2'b11, 2'b00, 2'b00, 2'b00);
    // R2 negative to zero / over max
    drive(3'd1, 48'hFFFF_FFFF_FFFF, 48'h0100_0000_0000, 2'b11, 2'b00, 2'b10, 2'b00);
    // R3 mixed masks, no saturation
    drive(3'd3, 48'hFFFF_FFFF_FFFF, 48'h0100_0000_0005, 2'b11, 2'b11, 2'b11, 2'b00);
    // R4 bounds, half word with out-of-range sum
    drive(3'd4, 48'h0000_8000_0000, 48'hFFFF_7FFF_FFFF, 2'b11, 2'b00, 2'b00, 2'b00);
    // R5 wrap clamp and multiplier saturation in range
    drive(3'd5, 48'h00FF_8000_0000, 48'h0000_0000_0010, 2'b11, 2'b00, 2'b11, 2'b10);
    drive(3'd5, 48'h0000_8000_0000, 48'h0000_7FFF_FFFF, 2'b11, 2'b00, 2'b01, 2'b01);
    // R10 illegal right after saturation
    drive(3'd6, 48'h0000_0000_0001, 48'h0000_0000_0001, 2'b11, 2'b00, 2'b11, 2'b00);
    drive(3'd7, 48'h0, 48'h0, 2'b00, 2'b00, 2'b00, 2'b00);
    // R8 idle lanes keep state, v clears
    drive(3'd0, 48'h0000_0000_0007, 48'h0, 2'b00, 2'b00, 2'b00, 2'b00);
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] m = ($urandom % 10 == 0) ? 3'(6 + $urandom % 2) : 3'($urandom % 6);
      drive(m, pick(), pick(), 2'($urandom % 4 == 0 ? $urandom % 4 : 3),
            2'($urandom), 2'($urandom), 2'($urandom % 3 == 0 ? $urandom : 0));
      if (i == 1500) begin
        rst = 1'b1;
        @(posedge clk);
        e_acc0 = '0; e_acc1 = '0; e_av0 = 0; e_avs0 = 0; e_av1 = 0; e_avs1 = 0;
        e_v = 0; e_vs = 0; e_ill = 0; t0 = "R11"; t1 = "R11";
        @(negedge clk);
        compare_all();
        rst = 1'b0;
      end
    end
    finish_run();
  end
endmodule